// File: doc/BRIEF.md
# I2C Bus Status Flag Tracker

This block watches the two wires of an I2C bus and keeps three status flags for the peripheral that owns it. The flags are a bus-activity flag, a master-role flag and a transfer-direction flag. The raw SDA and SCL levels pass through a multi-stage synchronizer. Start and Stop conditions are then found from edges on the synchronized SDA while SCL is high. Each condition is reported as a one-cycle pulse.

The rest of the peripheral supplies a few inputs: an enable, a pulse when it has generated a Start as master, a pulse when it loses arbitration, and a strobe when the whole address phase has finished, together with the R/W bit taken from that phase. Each flag has its own set and clear sources. The bus-activity flag keeps following the wires while the peripheral is disabled, so software can always see whether the bus is free. Every output is registered.

Top module: `i2c_flag_tracker`

## Requirements
- R1: After synchronous reset all outputs (`bus_busy`, `is_master`, `is_tx`, `start_seen`, `stop_seen`) are 0.
- R2: A Start (synchronized SDA falls while synchronized SCL stays high) raises `start_seen`, and a Stop (SDA rises while SCL stays high) raises `stop_seen`. Each pulse lasts exactly one cycle and appears 3 clock edges after the input change (2 synchronizer stages plus the output register).
- R3: `bus_busy` becomes 1 with the same 3-edge latency when either synchronized line is low.
- R4: `bus_busy` returns to 0 only on a detected Stop. Lines going high again without a Stop leave it at 1.
- R5: `bus_busy` tracks the bus identically while `enable` is 0.
- R6: With `enable`=1, an `addr_done` pulse loads `rw_bit` into `is_tx` on the next edge. A value of 1 means transmitting and 0 means receiving.
- R7: `is_tx` is cleared on the next edge by a Stop, a repeated Start, `arb_lost`, or `enable`=0. A clear wins over a simultaneous `addr_done`.
- R8: With `enable`=1, a `start_gen` pulse sets `is_master` on the next edge.
- R9: `is_master` is cleared on the next edge by a Stop, `arb_lost`, or `enable`=0. A clear wins over a simultaneous `start_gen`.
- R10: A Start seen while `bus_busy` is already 1 counts as a repeated Start and clears `is_tx`. A Start on an idle bus leaves `is_tx` unchanged, and neither kind of Start touches `is_master`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sda_in | input | 1 | Raw SDA level |
| scl_in | input | 1 | Raw SCL level |
| enable | input | 1 | Peripheral enable |
| start_gen | input | 1 | Pulse: Start generated as master |
| arb_lost | input | 1 | Pulse: arbitration lost |
| addr_done | input | 1 | Strobe: full address phase finished |
| rw_bit | input | 1 | Captured R/W bit of the address |
| bus_busy | output | 1 | Bus activity flag |
| is_master | output | 1 | Master role flag |
| is_tx | output | 1 | Transmit (1) / receive (0) flag |
| start_seen | output | 1 | One-cycle Start pulse |
| stop_seen | output | 1 | One-cycle Stop pulse |

## Verification
The hardest case to reach is the repeated Start, because it needs the bus already marked busy. To get there, the stimulus first issues a Start and sets the direction flag, then lowers SCL, raises SDA under the low clock and raises SCL. Only then does it drop SDA, so the second falling edge is seen with the activity flag already set. A Start on an idle bus with the direction flag preset shows the other side: that case must not clear the flag.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
  typedef struct packed {
    logic sda;
    logic scl;
  } bus_lines_t;

  localparam bus_lines_t LINES_IDLE = '{sda: 1'b1, scl: 1'b1};
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
  import i2c_flag_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  bus_lines_t raw,
  output bus_lines_t synced
);
  bus_lines_t chain [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[g] <= LINES_IDLE;
        else if (g == 0) chain[g] <= raw;
        else chain[g] <= chain[(g == 0) ? 0 : g - 1];
      end
    end
  endgenerate

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
  import i2c_flag_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  bus_lines_t lines,
  output logic       start_cond,
  output logic       stop_cond,
  output logic       any_low
);
  bus_lines_t prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= LINES_IDLE;
    else prev <= lines;
  end

  // SCL must be high both before and after the SDA edge
  always_comb begin
    start_cond = prev.sda && !lines.sda && prev.scl && lines.scl;
    stop_cond  = !prev.sda && lines.sda && prev.scl && lines.scl;
    any_low    = !lines.sda || !lines.scl;
  end
endmodule

// File: rtl/i2c_flag_regs.sv
module i2c_flag_regs (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic start_cond,
  input  logic stop_cond,
  input  logic any_low,
  input  logic start_gen,
  input  logic arb_lost,
  input  logic addr_done,
  input  logic rw_bit,
  output logic bus_busy,
  output logic is_master,
  output logic is_tx,
  output logic start_seen,
  output logic stop_seen
);
  logic rep_start;
  logic tx_clear;
  logic ms_clear;

  always_comb begin
    rep_start = start_cond && bus_busy;
    tx_clear  = !enable || stop_cond || rep_start || arb_lost;
    ms_clear  = !enable || stop_cond || arb_lost;
  end

  // activity flag ignores enable
  always_ff @(posedge clk) begin
    if (rst) bus_busy <= 1'b0;
    else if (stop_cond) bus_busy <= 1'b0;
    else if (any_low) bus_busy <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) is_tx <= 1'b0;
    else if (tx_clear) is_tx <= 1'b0;
    else if (addr_done) is_tx <= rw_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) is_master <= 1'b0;
    else if (ms_clear) is_master <= 1'b0;
    else if (start_gen) is_master <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      start_seen <= start_cond;
      stop_seen  <= stop_cond;
    end
  end
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker
  import i2c_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sda_in,
  input  logic scl_in,
  input  logic enable,
  input  logic start_gen,
  input  logic arb_lost,
  input  logic addr_done,
  input  logic rw_bit,
  output logic bus_busy,
  output logic is_master,
  output logic is_tx,
  output logic start_seen,
  output logic stop_seen
);
  bus_lines_t raw_lines;
  bus_lines_t sync_lines;
  logic start_cond;
  logic stop_cond;
  logic any_low;

  assign raw_lines = '{sda: sda_in, scl: scl_in};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(raw_lines), .synced(sync_lines)
  );

  i2c_cond_detect u_cond (
    .clk(clk), .rst(rst), .lines(sync_lines),
    .start_cond(start_cond), .stop_cond(stop_cond), .any_low(any_low)
  );

  i2c_flag_regs u_flags (
    .clk(clk), .rst(rst), .enable(enable),
    .start_cond(start_cond), .stop_cond(stop_cond), .any_low(any_low),
    .start_gen(start_gen), .arb_lost(arb_lost),
    .addr_done(addr_done), .rw_bit(rw_bit),
    .bus_busy(bus_busy), .is_master(is_master), .is_tx(is_tx),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );
endmodule

// File: rtl/i2c_flag_tracker_chk.sv
module i2c_flag_tracker_chk (
  input logic clk,
  input logic rst,
  input logic enable,
  input logic start_gen,
  input logic arb_lost,
  input logic addr_done,
  input logic rw_bit,
  input logic bus_busy,
  input logic is_master,
  input logic is_tx,
  input logic start_seen,
  input logic stop_seen
);
  assert_start_stop_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(start_seen && stop_seen));

  assert_stop_frees_bus_R4: assert property (@(posedge clk) disable iff (rst)
    stop_seen |-> !bus_busy);

  assert_busy_falls_on_stop_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_busy) |-> stop_seen);

  assert_tx_off_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !is_tx);

  assert_tx_rise_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(is_tx) |-> $past(addr_done && rw_bit && enable));

  assert_master_rise_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(is_master) |-> $past(start_gen && enable));

  assert_master_off_disabled_R9: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !is_master);

  assert_arb_clears_R9: assert property (@(posedge clk) disable iff (rst)
    arb_lost |=> (!is_master && !is_tx));
endmodule

bind i2c_flag_tracker i2c_flag_tracker_chk u_chk (
  .clk(clk), .rst(rst), .enable(enable), .start_gen(start_gen),
  .arb_lost(arb_lost), .addr_done(addr_done), .rw_bit(rw_bit),
  .bus_busy(bus_busy), .is_master(is_master), .is_tx(is_tx),
  .start_seen(start_seen), .stop_seen(stop_seen)
);

// File: tb/tb_i2c_flag_tracker.sv
`timescale 1ns/1ps
module tb_i2c_flag_tracker;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sda_in = 1'b1, scl_in = 1'b1;
  logic enable = 1'b1, start_gen = 1'b0, arb_lost = 1'b0;
  logic addr_done = 1'b0, rw_bit = 1'b0;
  logic bus_busy, is_master, is_tx, start_seen, stop_seen;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  i2c_flag_tracker dut (
    .clk(clk), .rst(rst), .sda_in(sda_in), .scl_in(scl_in),
    .enable(enable), .start_gen(start_gen), .arb_lost(arb_lost),
    .addr_done(addr_done), .rw_bit(rw_bit),
    .bus_busy(bus_busy), .is_master(is_master), .is_tx(is_tx),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // change lines, then sample where the 3-edge latency lands
  task automatic lines(input logic sda, input logic scl);
    sda_in = sda;
    scl_in = scl;
    wait_n(3);
  endtask

  task automatic pulse_addr(input logic rw, input logic arb);
    addr_done = 1'b1; rw_bit = rw; arb_lost = arb;
    wait_n(1);
    addr_done = 1'b0; arb_lost = 1'b0;
  endtask

  task automatic pulse_sg(input logic arb);
    start_gen = 1'b1; arb_lost = arb;
    wait_n(1);
    start_gen = 1'b0; arb_lost = 1'b0;
  endtask

  task automatic do_stop();
    lines(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
  endtask

  task automatic t_reset();
    chk("R1 busy", bus_busy, 1'b0);
    chk("R1 master", is_master, 1'b0);
    chk("R1 tx", is_tx, 1'b0);
    chk("R1 start", start_seen, 1'b0);
    chk("R1 stop", stop_seen, 1'b0);
  endtask

  task automatic t_start_stop();
    lines(1'b0, 1'b1);
    chk("R2 start pulse", start_seen, 1'b1);
    chk("R3 busy on sda low", bus_busy, 1'b1);
    wait_n(1);
    chk("R2 start one cycle", start_seen, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    chk("R4 no stop under low scl", stop_seen, 1'b0);
    chk("R4 busy holds", bus_busy, 1'b1);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    chk("R2 stop pulse", stop_seen, 1'b1);
    chk("R4 busy cleared on stop", bus_busy, 1'b0);
    wait_n(1);
    chk("R2 stop one cycle", stop_seen, 1'b0);
  endtask

  task automatic t_scl_low();
    lines(1'b1, 1'b0);
    chk("R3 busy on scl low", bus_busy, 1'b1);
    chk("R2 no start on scl low", start_seen, 1'b0);
    lines(1'b1, 1'b1);
    chk("R4 busy stays without stop", bus_busy, 1'b1);
    do_stop();
    chk("R4 busy cleared", bus_busy, 1'b0);
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    wait_n(1);
    lines(1'b0, 1'b1);
    chk("R5 busy set while disabled", bus_busy, 1'b1);
    pulse_sg(1'b0);
    chk("R9 no master while disabled", is_master, 1'b0);
    pulse_addr(1'b1, 1'b0);
    chk("R7 no tx while disabled", is_tx, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    chk("R5 busy cleared while disabled", bus_busy, 1'b0);
    enable = 1'b1;
    wait_n(1);
  endtask

  task automatic t_tx();
    pulse_addr(1'b1, 1'b0);
    chk("R6 tx loads 1", is_tx, 1'b1);
    pulse_addr(1'b0, 1'b0);
    chk("R6 tx loads 0", is_tx, 1'b0);
    pulse_addr(1'b1, 1'b0);
    arb_lost = 1'b1; wait_n(1); arb_lost = 1'b0;
    chk("R7 arb clears tx", is_tx, 1'b0);
    pulse_addr(1'b1, 1'b0);
    enable = 1'b0; wait_n(1); enable = 1'b1;
    chk("R7 disable clears tx", is_tx, 1'b0);
    pulse_addr(1'b1, 1'b1);
    chk("R7 clear beats load", is_tx, 1'b0);
  endtask

  task automatic t_master();
    pulse_sg(1'b0);
    chk("R8 master set", is_master, 1'b1);
    arb_lost = 1'b1; wait_n(1); arb_lost = 1'b0;
    chk("R9 arb clears master", is_master, 1'b0);
    pulse_sg(1'b0);
    enable = 1'b0; wait_n(1); enable = 1'b1;
    chk("R9 disable clears master", is_master, 1'b0);
    pulse_sg(1'b1);
    chk("R9 clear beats set", is_master, 1'b0);
  endtask

  task automatic t_repeated();
    pulse_addr(1'b1, 1'b0);
    lines(1'b0, 1'b1);
    chk("R10 idle start keeps tx", is_tx, 1'b1);
    pulse_sg(1'b0);
    lines(1'b0, 1'b0);
    lines(1'b1, 1'b0);
    lines(1'b1, 1'b1);
    chk("R10 tx before repeat", is_tx, 1'b1);
    lines(1'b0, 1'b1);
    chk("R10 repeat start pulse", start_seen, 1'b1);
    chk("R10 repeat start clears tx", is_tx, 1'b0);
    chk("R10 repeat start keeps master", is_master, 1'b1);
    pulse_addr(1'b1, 1'b0);
    lines(1'b0, 1'b0);
    lines(1'b0, 1'b1);
    lines(1'b1, 1'b1);
    chk("R2 stop pulse end", stop_seen, 1'b1);
    chk("R7 stop clears tx", is_tx, 1'b0);
    chk("R9 stop clears master", is_master, 1'b0);
    chk("R4 bus free", bus_busy, 1'b0);
  endtask

  initial begin
    wait_n(4);
    rst = 1'b0;
    wait_n(1);
    t_reset();
    t_start_stop();
    t_scl_low();
    t_disabled();
    t_tx();
    t_master();
    t_repeated();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule